// File: doc/BRIEF.md
# Streaming Hodgepodge Cellular-Automaton Generation Engine

The block computes one generation of a hodgepodge-style cellular automaton over a rectangular grid of 8-bit cells. The grid arrives as a raster stream, row after row and left to right, one cell per accepted handshake. The block returns the next-generation value of every cell in the same raster order. Each input cell is taken in exactly once. A chain of cell registers holds `(WIN-1)*GRID_W + WIN` cells, which is enough to expose a full `WIN`×`WIN` square window around the current centre cell. All window positions feed the transition logic in parallel, so the block produces one new cell per advance once the window has filled.

Window positions outside the grid read as state 0, so border cells see zeros there. After the last cell of a frame the block withdraws `in_ready` and pushes zeros through itself until the final centre cell has been evaluated. It then waits for the next start-of-frame. The window size `WIN` is an odd parameter: 3 gives the classic small neighbourhood, and values up to 29 give the large-neighbourhood variant. The two count divisors and the infection gain are also parameters.

Top module: `hodgepodge_stream`

## Requirements
- R1: After reset `out_valid` and `out_sof` are 0 and `in_ready` is 1.
- R2: The state encoding is: 0 is healthy, 1 to 254 are infected, and 255 is ill. A healthy centre becomes floor(a/K1) + floor(b/K2), saturated at 255. Here a is the number of infected cells in the window and b the number of ill cells, both excluding the centre.
- R3: An infected centre becomes floor(S/(a+b+1)) + GAIN, saturated at 255. S is the sum of all in-grid window states including the centre.
- R4: An ill centre (255) becomes 0.
- R5: Window positions whose row or column lies outside the grid contribute state 0. They never count as infected or ill.
- R6: Each frame produces exactly GRID_W*GRID_H outputs in raster order, one per input cell. `out_sof` is 1 on the first output of the frame only and is never 1 without `out_valid`. Cycles with `in_valid` low do not advance the stream.
- R7: With a gapless input stream, the first output of a frame appears `HALF*GRID_W + HALF + 1` clock cycles after the start-of-frame cell is accepted, where HALF = (WIN-1)/2.
- R8: While waiting for a frame, cells presented with `in_sof` = 0 are dropped. They produce no output and do not start a frame.
- R9: After the last cell of a frame is accepted, `in_ready` stays low for exactly `HALF*GRID_W + HALF` cycles. One output is delivered in the cycle after each of those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input cell present |
| in_ready | output | 1 | Block accepts a cell this cycle |
| in_sof | input | 1 | Marks the first cell of a frame |
| in_state | input | 8 | Current-generation cell state |
| out_valid | output | 1 | Next-generation cell present |
| out_sof | output | 1 | Marks the first output cell of a frame |
| out_state | output | 8 | Next-generation cell state |

## Verification
Two instances, one with a 3×3 window and one with a 5×5 window, run from one stream over a non-square grid. Every output is compared against a model of the rule. A uniformly random frame with input gaps checks the general rule and that stalls do not advance the stream. A frame of sparse high infected cells on a healthy background drives the infected result into saturation and also measures latency and the flush window. An all-ill frame must return all zeros. A frame biased towards 0 and 255 stresses the counts of a and b, and corner and edge cells tell correct zero-padding apart from column wrap-around. Stray cells sent without start-of-frame before the first frame must leave no trace.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int CELL_W  = 8;
  localparam int CELL_MAX = 255;

  typedef logic [CELL_W-1:0] cell_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_RUN   = 2'd1,
    PH_FLUSH = 2'd2
  } phase_e;
endpackage

// File: rtl/hp_window_store.sv
module hp_window_store
  import hp_pkg::*;
#(
  parameter int GRID_W = 32,
  parameter int WIN    = 9
) (
  input  logic                  clk,
  input  logic                  shift_en,
  input  cell_t                 din,
  output cell_t [WIN*WIN-1:0]   win_o
);
  localparam int DEPTH = (WIN - 1) * GRID_W + WIN;

  // Storage is left unreset: positions holding stale data are always masked.
  cell_t [DEPTH-1:0] sr_q;
  cell_t [DEPTH-1:0] sr_d;

  always_comb begin
    sr_d = sr_q;
    if (shift_en) begin
      sr_d = {sr_q[DEPTH-2:0], din};
    end
  end

  always_ff @(posedge clk) begin
    if (shift_en) begin
      sr_q <= sr_d;
    end
  end

  // Window row r (top = 0), column c (left = 0) taps the chain.
  for (genvar r = 0; r < WIN; r++) begin : g_row
    for (genvar c = 0; c < WIN; c++) begin : g_col
      assign win_o[r*WIN + c] = sr_q[(WIN-1-r)*GRID_W + (WIN-1-c)];
    end
  end
endmodule

// File: rtl/hp_scan_ctrl.sv
module hp_scan_ctrl
  import hp_pkg::*;
#(
  parameter int GRID_W = 32,
  parameter int GRID_H = 24,
  parameter int WIN    = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_sof,
  output logic                 in_ready,
  output logic                 shift_en,
  output logic                 push_zero,
  output logic                 cen_vld,
  output logic                 cen_first,
  output logic [WIN*WIN-1:0]   mask
);
  localparam int HALF   = (WIN - 1) / 2;
  localparam int TOTAL  = GRID_W * GRID_H;
  localparam int LAG    = HALF * GRID_W + HALF;
  localparam int LAST   = TOTAL + LAG - 1;
  localparam int PCNT_W = $clog2(LAST + 1);
  localparam int COL_W  = (GRID_W > 1) ? $clog2(GRID_W) : 1;
  localparam int ROW_W  = (GRID_H > 1) ? $clog2(GRID_H) : 1;

  phase_e            phase_q, phase_d;
  logic [PCNT_W-1:0] pcnt_q, pcnt_d;
  logic [COL_W-1:0]  col_q, col_d;
  logic [ROW_W-1:0]  row_q, row_d;
  logic              vld_q, vld_d;
  logic              accept;
  logic [PCNT_W-1:0] cur_p;
  logic [WIN-1:0]    row_ok;
  logic [WIN-1:0]    col_ok;

  assign in_ready  = (phase_q != PH_FLUSH);
  assign accept    = in_valid && in_ready && ((phase_q == PH_RUN) || in_sof);
  assign shift_en  = accept || (phase_q == PH_FLUSH);
  assign push_zero = (phase_q == PH_FLUSH);
  assign cur_p     = (phase_q == PH_IDLE) ? '0 : pcnt_q;
  assign cen_vld   = vld_q;
  assign cen_first = vld_q && (col_q == '0) && (row_q == '0);

  always_comb begin
    phase_d = phase_q;
    pcnt_d  = pcnt_q;
    col_d   = col_q;
    row_d   = row_q;
    vld_d   = 1'b0;
    if (shift_en) begin
      pcnt_d = cur_p + PCNT_W'(1);
      if (cur_p >= PCNT_W'(LAG)) begin
        vld_d = 1'b1;
        if (cur_p == PCNT_W'(LAG)) begin
          col_d = '0;
          row_d = '0;
        end else if (col_q == COL_W'(GRID_W - 1)) begin
          col_d = '0;
          row_d = row_q + ROW_W'(1);
        end else begin
          col_d = col_q + COL_W'(1);
        end
      end
    end
    unique case (phase_q)
      PH_IDLE:  if (accept) phase_d = PH_RUN;
      PH_RUN:   if (accept && (pcnt_q == PCNT_W'(TOTAL - 1))) phase_d = PH_FLUSH;
      PH_FLUSH: if (pcnt_q == PCNT_W'(LAST)) phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      pcnt_q  <= '0;
      col_q   <= '0;
      row_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      pcnt_q  <= pcnt_d;
      col_q   <= col_d;
      row_q   <= row_d;
      vld_q   <= vld_d;
    end
  end

  // Border test per window row and column, relative to the centre.
  always_comb begin
    int rr;
    int cc;
    for (int i = 0; i < WIN; i++) begin
      rr = int'(row_q) + i - HALF;
      cc = int'(col_q) + i - HALF;
      row_ok[i] = (rr >= 0) && (rr < GRID_H);
      col_ok[i] = (cc >= 0) && (cc < GRID_W);
    end
  end

  for (genvar r = 0; r < WIN; r++) begin : g_mr
    for (genvar c = 0; c < WIN; c++) begin : g_mc
      assign mask[r*WIN + c] = row_ok[r] & col_ok[c];
    end
  end
endmodule

// File: rtl/hp_rule.sv
module hp_rule
  import hp_pkg::*;
#(
  parameter int WIN  = 9,
  parameter int K1   = 2,
  parameter int K2   = 3,
  parameter int GAIN = 28
) (
  input  cell_t [WIN*WIN-1:0] win,
  input  logic  [WIN*WIN-1:0] mask,
  output cell_t               nxt
);
  localparam int CELLS = WIN * WIN;
  localparam int CTR   = CELLS / 2;
  localparam int CNT_W = $clog2(CELLS + 1);
  localparam int SUM_W = CELL_W + CNT_W;

  logic [CNT_W-1:0] a_cnt;
  logic [CNT_W-1:0] b_cnt;
  logic [SUM_W-1:0] sum;
  logic [CNT_W:0]   h_val;
  logic [CNT_W:0]   div;
  logic [SUM_W:0]   i_val;
  cell_t            centre;

  always_comb begin
    a_cnt = '0;
    b_cnt = '0;
    sum   = '0;
    for (int i = 0; i < CELLS; i++) begin
      if (mask[i]) begin
        sum = sum + SUM_W'(win[i]);
        if (i != CTR) begin
          if (win[i] == cell_t'(CELL_MAX)) begin
            b_cnt = b_cnt + CNT_W'(1);
          end else if (win[i] != '0) begin
            a_cnt = a_cnt + CNT_W'(1);
          end
        end
      end
    end
  end

  assign centre = win[CTR];

  always_comb begin
    h_val = (CNT_W+1)'(a_cnt / CNT_W'(K1)) + (CNT_W+1)'(b_cnt / CNT_W'(K2));
    div   = (CNT_W+1)'(a_cnt) + (CNT_W+1)'(b_cnt) + (CNT_W+1)'(1);
    i_val = (SUM_W+1)'(sum / SUM_W'(div)) + (SUM_W+1)'(GAIN);
    if (centre == '0) begin
      nxt = (int'(h_val) > CELL_MAX) ? cell_t'(CELL_MAX) : cell_t'(h_val);
    end else if (centre == cell_t'(CELL_MAX)) begin
      nxt = '0;
    end else begin
      nxt = (int'(i_val) > CELL_MAX) ? cell_t'(CELL_MAX) : cell_t'(i_val);
    end
  end
endmodule

// File: rtl/hodgepodge_stream.sv
module hodgepodge_stream
  import hp_pkg::*;
#(
  parameter int GRID_W = 32,
  parameter int GRID_H = 24,
  parameter int WIN    = 9,
  parameter int K1     = 2,
  parameter int K2     = 3,
  parameter int GAIN   = 28
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_sof,
  input  logic [7:0] in_state,
  output logic       out_valid,
  output logic       out_sof,
  output logic [7:0] out_state
);
  localparam int CELLS = WIN * WIN;

  logic                shift_en;
  logic                push_zero;
  logic                cen_vld;
  logic                cen_first;
  logic [CELLS-1:0]    mask;
  cell_t [CELLS-1:0]   win;
  cell_t               din;
  cell_t               nxt_state;

  logic  out_valid_q, out_valid_d;
  logic  out_sof_q, out_sof_d;
  cell_t out_state_q, out_state_d;

  assign din = push_zero ? '0 : cell_t'(in_state);

  hp_scan_ctrl #(.GRID_W(GRID_W), .GRID_H(GRID_H), .WIN(WIN)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_ready  (in_ready),
    .shift_en  (shift_en),
    .push_zero (push_zero),
    .cen_vld   (cen_vld),
    .cen_first (cen_first),
    .mask      (mask)
  );

  hp_window_store #(.GRID_W(GRID_W), .WIN(WIN)) u_store (
    .clk      (clk),
    .shift_en (shift_en),
    .din      (din),
    .win_o    (win)
  );

  hp_rule #(.WIN(WIN), .K1(K1), .K2(K2), .GAIN(GAIN)) u_rule (
    .win  (win),
    .mask (mask),
    .nxt  (nxt_state)
  );

  always_comb begin
    out_valid_d = cen_vld;
    out_sof_d   = cen_first;
    out_state_d = out_state_q;
    if (cen_vld) begin
      out_state_d = nxt_state;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_sof_q   <= 1'b0;
      out_state_q <= '0;
    end else begin
      out_valid_q <= out_valid_d;
      out_sof_q   <= out_sof_d;
      out_state_q <= out_state_d;
    end
  end

  assign out_valid = out_valid_q;
  assign out_sof   = out_sof_q;
  assign out_state = out_state_q;
endmodule

// File: rtl/hodgepodge_stream_chk.sv
module hodgepodge_stream_chk
  import hp_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   in_valid,
  input logic   in_ready,
  input logic   in_sof,
  input logic   out_valid,
  input logic   out_sof,
  input phase_e phase
);
  // R6
  sof_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);

  // R9
  flush_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> out_valid);

  // R9
  ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(in_valid && in_ready));

  // R8
  idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && in_valid && !in_sof) |=> (phase == PH_IDLE));
endmodule

bind hodgepodge_stream hodgepodge_stream_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_sof    (in_sof),
  .out_valid (out_valid),
  .out_sof   (out_sof),
  .phase     (u_ctrl.phase_q)
);

// File: tb/tb_hodgepodge_stream.sv
module tb_hodgepodge_stream;
  localparam int W     = 7;
  localparam int H     = 6;
  localparam int TOTAL = W * H;
  localparam int LAG3  = 1 * W + 1;
  localparam int LAG5  = 2 * W + 2;

  logic clk;
  logic rst_n;
  logic in_valid;
  logic in_sof;
  logic [7:0] in_state;
  logic rdy3, ov3, os3;
  logic rdy5, ov5, os5;
  logic [7:0] od3, od5;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int grid[TOTAL];
  int idx3 = 0;
  int idx5 = 0;
  int first3 = -1;
  int first5 = -1;
  int sof_cyc = 0;

  hodgepodge_stream #(.GRID_W(W), .GRID_H(H), .WIN(3)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy3),
    .in_sof(in_sof), .in_state(in_state),
    .out_valid(ov3), .out_sof(os3), .out_state(od3));

  hodgepodge_stream #(.GRID_W(W), .GRID_H(H), .WIN(5)) dut5 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy5),
    .in_sof(in_sof), .in_state(in_state),
    .out_valid(ov5), .out_sof(os5), .out_state(od5));

  initial clk = 1'b0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int model(input int k, input int idx);
    int h, r0, c0, a, b, s, v, cen, res;
    h = (k - 1) / 2; r0 = idx / W; c0 = idx % W;
    a = 0; b = 0; s = 0; cen = grid[idx];
    for (int dr = -h; dr <= h; dr++) begin
      for (int dc = -h; dc <= h; dc++) begin
        if (r0 + dr >= 0 && r0 + dr < H && c0 + dc >= 0 && c0 + dc < W) begin
          v = grid[(r0 + dr) * W + c0 + dc];
          s += v;
          if (!(dr == 0 && dc == 0)) begin
            if (v == 255) b++;
            else if (v != 0) a++;
          end
        end
      end
    end
    if (cen == 0) res = a / 2 + b / 3;
    else if (cen == 255) res = 0;
    else res = s / (a + b + 1) + 28;
    if (res > 255) res = 255;
    return res;
  endfunction

  function automatic string tag_of(input int k, input int idx);
    int h = (k - 1) / 2;
    int r0 = idx / W;
    int c0 = idx % W;
    if (r0 < h || r0 >= H - h || c0 < h || c0 >= W - h) return "R5";
    if (grid[idx] == 0) return "R2";
    if (grid[idx] == 255) return "R4";
    return "R3";
  endfunction

  // Output monitors, sampled on the falling edge.
  always @(negedge clk) begin
    if (rst_n && ov3) begin
      if (idx3 == 0) first3 = cyc;
      if (idx3 < TOTAL) begin
        check(od3 == 8'(model(3, idx3)), tag_of(3, idx3), "K3 cell", od3, model(3, idx3));
        check(os3 == (idx3 == 0), "R6", "K3 out_sof", os3, idx3 == 0);
      end else begin
        check(1'b0, "R6", "K3 extra output index", idx3, TOTAL - 1);
      end
      idx3++;
    end
    if (rst_n && ov5) begin
      if (idx5 == 0) first5 = cyc;
      if (idx5 < TOTAL) begin
        check(od5 == 8'(model(5, idx5)), tag_of(5, idx5), "K5 cell", od5, model(5, idx5));
        check(os5 == (idx5 == 0), "R6", "K5 out_sof", os5, idx5 == 0);
      end else begin
        check(1'b0, "R6", "K5 extra output index", idx5, TOTAL - 1);
      end
      idx5++;
    end
  end

  task automatic send_frame(input int gap, input bit measure);
    int lo3 = 0;
    int lo5 = 0;
    idx3 = 0; idx5 = 0; first3 = -1; first5 = -1;
    for (int i = 0; i < TOTAL; i++) begin
      while (int'($urandom % 100) < gap) begin
        in_valid = 1'b0; @(negedge clk);
      end
      while (!(rdy3 && rdy5)) begin
        in_valid = 1'b0; @(negedge clk);
      end
      in_valid = 1'b1; in_sof = (i == 0); in_state = 8'(grid[i]);
      if (i == 0) sof_cyc = cyc + 1;
      @(negedge clk);
    end
    in_valid = 1'b0; in_sof = 1'b0;
    while (!(rdy3 && rdy5)) begin
      if (!rdy3) lo3++;
      if (!rdy5) lo5++;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    check(idx3 == TOTAL, "R6", "K3 output count", idx3, TOTAL);
    check(idx5 == TOTAL, "R6", "K5 output count", idx5, TOTAL);
    if (measure) begin
      check(first3 - sof_cyc == LAG3 + 1, "R7", "K3 latency", first3 - sof_cyc, LAG3 + 1);
      check(first5 - sof_cyc == LAG5 + 1, "R7", "K5 latency", first5 - sof_cyc, LAG5 + 1);
      check(lo3 == LAG3, "R9", "K3 ready-low cycles", lo3, LAG3);
      check(lo5 == LAG5, "R9", "K5 ready-low cycles", lo5, LAG5);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_state = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(!ov3 && !os3 && rdy3, "R1", "K3 reset outputs", {ov3, os3, rdy3}, 1);
    check(!ov5 && !os5 && rdy5, "R1", "K5 reset outputs", {ov5, os5, rdy5}, 1);

    // R8: cells without start-of-frame while idle are dropped.
    for (int i = 0; i < 6; i++) begin
      in_valid = 1'b1; in_sof = 1'b0; in_state = 8'($urandom);
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (LAG5 + 4) @(negedge clk);
    check(idx3 == 0 && idx5 == 0, "R8", "outputs after stray cells", idx3 + idx5, 0);
    check(rdy3 && rdy5, "R8", "ready after stray cells", {rdy3, rdy5}, 3);

    // Frame 1: uniform random states with input gaps (R2..R6).
    for (int i = 0; i < TOTAL; i++) grid[i] = int'($urandom % 256);
    send_frame(30, 1'b0);

    // Frame 2: sparse high infected and ill cells, gapless (R3 saturation, R7, R9).
    for (int i = 0; i < TOTAL; i++)
      grid[i] = (i % 5 == 0) ? 250 : ((i % 7 == 3) ? 255 : 0);
    send_frame(0, 1'b1);

    // Frame 3: every cell ill, all results must be 0 (R4).
    for (int i = 0; i < TOTAL; i++) grid[i] = 255;
    send_frame(0, 1'b0);

    // Frame 4: biased towards healthy and ill with random infected (R2, R3).
    for (int i = 0; i < TOTAL; i++) begin
      case ($urandom % 3)
        0: grid[i] = 0;
        1: grid[i] = 255;
        default: grid[i] = int'($urandom % 256);
      endcase
    end
    send_frame(50, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule